// File: doc/BRIEF.md
# Tracking Position Output Port

This block is the digital back end of a tracking position converter. It keeps an up/down position count of configurable resolution, from 1 to 16 bits. The count moves by one LSB for each step strobe, in the direction given by the direction input. Each step raises a busy pulse a fixed number of clocks long. At the end of that pulse, the count is copied into an output latch.

A host reads the latch over two byte-wide buses. Each bus has its own drive enable, which stands in for a tri-state pin. To read a steady value, the host pulls the active-low inhibit input low. This stops latch updates, while the counter keeps tracking the steps. The host then waits for the valid flag and reads the two bytes, selecting bytes with the byte-select input. When the host releases inhibit, the block raises a refresh busy pulse on its own. That pulse loads the count that built up in the meantime.

Two small state machines control the block:
- **Busy machine.** Its states are BZ_IDLE and BZ_PULSE.
  - BZ_IDLE goes to BZ_PULSE on a step or on an inhibit release.
  - BZ_PULSE stays in BZ_PULSE while its timer runs down.
  - When the timer reaches zero, BZ_PULSE either restarts itself or returns to BZ_IDLE. It restarts if a step or release arrived during the pulse, and returns to BZ_IDLE otherwise.
- **Valid machine.** Its states are VL_READY and VL_HOLD.
  - VL_READY goes to VL_HOLD on the falling edge of inhibit.
  - VL_HOLD returns to VL_READY when its delay counter expires or when inhibit is released.

Top module: `track_pos_port`

## Requirements
- R1: Each clock with `step_i` high moves the count by one: up when `dir_up_i` is 1 and down when it is 0. The count wraps modulo 2^RES_BITS. Every step is counted, whatever the state of the inhibit, enable or byte-select inputs.
- R2: A step in BZ_IDLE raises `busy_o` on the next clock for exactly BUSY_CYC cycles. On the clock that ends the pulse, the latch loads the count as it stood one clock before that edge. The latch changes at no other time.
- R3: A step or inhibit release during BZ_PULSE is not lost. When the timer ends, the machine starts a new pulse at once, so `busy_o` stays high without a gap.
- R4: A pulse that starts while `inhibit_n_i` is 0 does not load the latch. The counter keeps following steps while inhibit is low.
- R5: `valid_o` goes low on the first clock that samples `inhibit_n_i` low after it was high. It returns high VALID_DLY clocks later, or on the first clock that samples inhibit high again, whichever comes first. A pulse already running when inhibit falls still completes its load, and VALID_DLY >= BUSY_CYC ensures that this load finishes before `valid_o` rises.
- R6: When `inhibit_n_i` returns high, a busy pulse follows without any step, and it loads the current count.
- R7: With `enable_n_i` = 1, both bus drive enables are 0. With `enable_n_i` = 0, both are 1. The enables follow the input combinationally.
- R8: `db_low_o` carries latch bits [7:0]. `db_main_o` carries latch bits [15:8] when `byte_sel_i` = 1, and repeats latch bits [7:0] when `byte_sel_i` = 0.
- R9: Latch bits at position RES_BITS and above always read 0.
- R10: Neither `enable_n_i` nor `byte_sel_i` has any effect on counting, busy pulses, latching or `valid_o`.
- R11: Reset (`rst_n` low) clears the count and the latch to 0, sets `busy_o` to 0 and sets `valid_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One-LSB step strobe, sampled each clock |
| dir_up_i | input | 1 | Step direction: 1 = up, 0 = down |
| inhibit_n_i | input | 1 | 0 freezes counter-to-latch transfers |
| enable_n_i | input | 1 | 0 drives both data buses |
| byte_sel_i | input | 1 | 1 = high byte on main bus, 0 = low byte |
| busy_o | output | 1 | Busy pulse, one per transfer request |
| valid_o | output | 1 | Latched data is stable and may be read |
| db_main_o | output | 8 | Main data bus (byte selected) |
| db_main_oe_o | output | 1 | Drive enable of the main bus |
| db_low_o | output | 8 | Low-byte data bus |
| db_low_oe_o | output | 1 | Drive enable of the low-byte bus |

## Verification
The bench drives several kinds of step traffic:
- Isolated steps with idle gaps, which check the pulse width and the load point.
- Back-to-back strobes, which show whether a pulse restarts with no gap rather than dropping steps.
- A downward run through zero, which exposes wrap errors.

Inhibit is tested three ways:
- Held low across several steps, which separates counting from latching.
- Dropped in the middle of a pulse, which shows whether the pending load still completes.
- Released before the delay runs out, which tests the early return of the valid flag.

A long random mix then toggles enable and byte select while steps run. A reference model predicts every output on every clock, so any coupling between the read side and the tracking side shows up as a mismatch.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

    localparam int POS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic {
        BZ_IDLE,
        BZ_PULSE
    } busy_st_t;

    typedef enum logic {
        VL_READY,
        VL_HOLD
    } valid_st_t;

endpackage

// File: rtl/tpp_step_counter.sv
module tpp_step_counter #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                up_i,
    output logic [RES_BITS-1:0] cnt_o
);

    localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

    logic [RES_BITS-1:0] cnt_q;
    logic [RES_BITS-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) begin
            cnt_d = up_i ? (cnt_q + ONE) : (cnt_q - ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    // R1
    no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q));

    // R1
    step_up_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/tpp_busy_ctl.sv
module tpp_busy_ctl
    import tpp_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int BUSY_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                inh_n_i,
    input  logic [RES_BITS-1:0] cnt_i,
    output logic                busy_o,
    output logic [POS_W-1:0]    latch_o
);

    localparam int          TW   = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;
    localparam logic [TW-1:0] TMAX = TW'(BUSY_CYC - 1);
    localparam logic [TW-1:0] TONE = TW'(1);

    busy_st_t           st_q, st_d;
    logic [TW-1:0]      tmr_q, tmr_d;
    logic               pend_q, pend_d;
    logic               xfer_q, xfer_d;
    logic               inh_q;
    logic               load;
    logic               req;
    logic [POS_W-1:0]   latch_q;
    logic [POS_W-1:0]   padded;

    assign req = step_i | (inh_n_i & ~inh_q);

    always_comb begin
        padded = '0;
        padded[RES_BITS-1:0] = cnt_i;
    end

    always_comb begin
        st_d   = st_q;
        tmr_d  = tmr_q;
        pend_d = pend_q;
        xfer_d = xfer_q;
        load   = 1'b0;
        unique case (st_q)
            BZ_IDLE: begin
                if (req) begin
                    st_d   = BZ_PULSE;
                    tmr_d  = TMAX;
                    xfer_d = inh_n_i;
                    pend_d = 1'b0;
                end
            end
            BZ_PULSE: begin
                if (tmr_q == '0) begin
                    load = xfer_q;
                    if (pend_q || req) begin
                        st_d   = BZ_PULSE;
                        tmr_d  = TMAX;
                        xfer_d = inh_n_i;
                    end else begin
                        st_d = BZ_IDLE;
                    end
                    pend_d = 1'b0;
                end else begin
                    tmr_d = tmr_q - TONE;
                    if (req) begin
                        pend_d = 1'b1;
                    end
                end
            end
            default: st_d = BZ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= BZ_IDLE;
            tmr_q   <= '0;
            pend_q  <= 1'b0;
            xfer_q  <= 1'b0;
            inh_q   <= 1'b1;
            latch_q <= '0;
        end else begin
            st_q   <= st_d;
            tmr_q  <= tmr_d;
            pend_q <= pend_d;
            xfer_q <= xfer_d;
            inh_q  <= inh_n_i;
            if (load) begin
                latch_q <= padded;
            end
        end
    end

    always_comb begin
        busy_o  = (st_q == BZ_PULSE);
        latch_o = latch_q;
    end

    // R2
    idle_step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BZ_IDLE && step_i) |=> busy_o);

    // R3
    busy_step_extends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i) |=> busy_o);

    // R2
    latch_at_pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |-> $past(st_q == BZ_PULSE && tmr_q == '0));

    // R9
    generate
        if (RES_BITS < POS_W) begin : g_pad_chk
            pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                latch_q[POS_W-1:RES_BITS] == '0);
        end
    endgenerate

endmodule

// File: rtl/tpp_valid_ctl.sv
module tpp_valid_ctl
    import tpp_pkg::*;
#(
    parameter int VALID_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inh_n_i,
    output logic valid_o
);

    localparam int          VW   = $clog2(VALID_DLY + 1);
    localparam logic [VW-1:0] VMAX = VW'(VALID_DLY);
    localparam logic [VW-1:0] VONE = VW'(1);

    valid_st_t      st_q, st_d;
    logic [VW-1:0]  vc_q, vc_d;
    logic           inh_q;
    logic           fall;

    assign fall = ~inh_n_i & inh_q;

    always_comb begin
        st_d = st_q;
        vc_d = vc_q;
        unique case (st_q)
            VL_READY: begin
                if (fall) begin
                    st_d = VL_HOLD;
                    vc_d = VMAX;
                end
            end
            VL_HOLD: begin
                if (inh_n_i || vc_q == VONE) begin
                    st_d = VL_READY;
                end else begin
                    vc_d = vc_q - VONE;
                end
            end
            default: st_d = VL_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= VL_READY;
            vc_q  <= '0;
            inh_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            vc_q  <= vc_d;
            inh_q <= inh_n_i;
        end
    end

    always_comb begin
        valid_o = (st_q == VL_READY);
    end

    // R5
    inhibit_fall_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !valid_o);

    // R5
    inhibit_high_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inh_n_i |=> valid_o);

endmodule

// File: rtl/tpp_byte_mux.sv
module tpp_byte_mux
    import tpp_pkg::*;
(
    input  logic [POS_W-1:0]  latch_i,
    input  logic              en_n_i,
    input  logic              bsel_i,
    output logic [BYTE_W-1:0] main_d_o,
    output logic              main_oe_o,
    output logic [BYTE_W-1:0] low_d_o,
    output logic              low_oe_o
);

    always_comb begin
        low_d_o   = latch_i[BYTE_W-1:0];
        main_d_o  = bsel_i ? latch_i[POS_W-1:BYTE_W] : latch_i[BYTE_W-1:0];
        main_oe_o = ~en_n_i;
        low_oe_o  = ~en_n_i;
    end

    always_comb begin
        // R8
        if (!bsel_i) begin
            mirror_low_chk: assert (main_d_o == low_d_o);
        end
        // R7
        oe_pair_chk: assert (main_oe_o == low_oe_o);
    end

endmodule

// File: rtl/track_pos_port.sv
module track_pos_port
    import tpp_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int BUSY_CYC  = 3,
    parameter int VALID_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       dir_up_i,
    input  logic       inhibit_n_i,
    input  logic       enable_n_i,
    input  logic       byte_sel_i,
    output logic       busy_o,
    output logic       valid_o,
    output logic [7:0] db_main_o,
    output logic       db_main_oe_o,
    output logic [7:0] db_low_o,
    output logic       db_low_oe_o
);

    logic [RES_BITS-1:0] cnt;
    logic [POS_W-1:0]    latch;

    tpp_step_counter #(
        .RES_BITS (RES_BITS)
    ) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .up_i   (dir_up_i),
        .cnt_o  (cnt)
    );

    tpp_busy_ctl #(
        .RES_BITS (RES_BITS),
        .BUSY_CYC (BUSY_CYC)
    ) i_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .inh_n_i (inhibit_n_i),
        .cnt_i   (cnt),
        .busy_o  (busy_o),
        .latch_o (latch)
    );

    tpp_valid_ctl #(
        .VALID_DLY (VALID_DLY)
    ) i_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .inh_n_i (inhibit_n_i),
        .valid_o (valid_o)
    );

    tpp_byte_mux i_mux (
        .latch_i   (latch),
        .en_n_i    (enable_n_i),
        .bsel_i    (byte_sel_i),
        .main_d_o  (db_main_o),
        .main_oe_o (db_main_oe_o),
        .low_d_o   (db_low_o),
        .low_oe_o  (db_low_oe_o)
    );

endmodule

// File: tb/test_track_pos_port.sv
module test_track_pos_port;

    localparam int CLK_P = 10;
    localparam int RES   = 12;
    localparam int BC    = 3;
    localparam int VD    = 4;
    localparam int MOD   = 1 << RES;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic       dir_up_i = 1'b1;
    logic       inhibit_n_i = 1'b1;
    logic       enable_n_i = 1'b1;
    logic       byte_sel_i = 1'b1;
    logic       busy_o, valid_o, db_main_oe_o, db_low_oe_o;
    logic [7:0] db_main_o, db_low_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R1";

    int m_cnt, m_latch, m_tmr, m_vt, old_cnt;
    bit m_busy, m_pend, m_xfer, m_inhq, m_valid;
    bit rise, fall, req;

    track_pos_port #(.RES_BITS(RES), .BUSY_CYC(BC), .VALID_DLY(VD)) i_track_pos_port (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_up_i(dir_up_i),
        .inhibit_n_i(inhibit_n_i), .enable_n_i(enable_n_i), .byte_sel_i(byte_sel_i),
        .busy_o(busy_o), .valid_o(valid_o),
        .db_main_o(db_main_o), .db_main_oe_o(db_main_oe_o),
        .db_low_o(db_low_o), .db_low_oe_o(db_low_oe_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req_s, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h exp %0h", req_s, what, got, exp);
        end
    endtask

    // reference model: update on each edge, compare a quarter period later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_latch = 0; m_tmr = 0; m_vt = 0;
            m_busy = 0; m_pend = 0; m_xfer = 0; m_inhq = 1; m_valid = 1;
        end else begin
            rise = inhibit_n_i && !m_inhq;
            fall = !inhibit_n_i && m_inhq;
            req  = step_i || rise;
            old_cnt = m_cnt;
            if (step_i) m_cnt = dir_up_i ? (m_cnt + 1) % MOD : (m_cnt + MOD - 1) % MOD;
            if (!m_busy) begin
                if (req) begin m_busy = 1; m_tmr = BC - 1; m_xfer = inhibit_n_i; m_pend = 0; end
            end else if (m_tmr == 0) begin
                if (m_xfer) m_latch = old_cnt;
                if (m_pend || req) begin m_tmr = BC - 1; m_xfer = inhibit_n_i; end
                else m_busy = 0;
                m_pend = 0;
            end else begin
                m_tmr--;
                if (req) m_pend = 1;
            end
            if (m_valid) begin
                if (fall) begin m_valid = 0; m_vt = VD; end
            end else if (inhibit_n_i || m_vt == 1) m_valid = 1;
            else m_vt--;
            m_inhq = inhibit_n_i;
        end
        #(CLK_P/4);
        if (!done) begin
            chk("R2", "busy", busy_o, m_busy);
            chk("R5", "valid", valid_o, m_valid);
            chk("R7", "main_oe", db_main_oe_o, !enable_n_i);
            chk("R7", "low_oe", db_low_oe_o, !enable_n_i);
            if (!enable_n_i) begin
                chk(tag, "low_bus", db_low_o, m_latch & 8'hff);
                chk(tag, "main_bus", db_main_o,
                    byte_sel_i ? (m_latch >> 8) & 8'hff : m_latch & 8'hff);
                if (byte_sel_i) chk("R9", "main_bus_pad", int'(db_main_o[7:4]), 0);
            end
        end
    end

    task automatic tick(input bit s, input bit up, input bit inh, input bit en_n, input bit bs);
        step_i = s; dir_up_i = up; inhibit_n_i = inh; enable_n_i = en_n; byte_sel_i = bs;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(0, 1, inhibit_n_i, enable_n_i, byte_sel_i);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state seen at the ports
        enable_n_i = 0;
        #1;
        chk("R11", "reset_busy", busy_o, 0);
        chk("R11", "reset_valid", valid_o, 1);
        chk("R11", "reset_low", db_low_o, 0);
        chk("R11", "reset_main", db_main_o, 0);
        @(negedge clk);
        rst_n = 1;
        // R1 R2: isolated steps upward
        tag = "R1";
        for (int k = 0; k < 3; k++) begin tick(1, 1, 1, 0, 1); idle(5); end
        // R3: back-to-back strobes
        tag = "R3";
        for (int k = 0; k < 5; k++) tick(1, 1, 1, 0, 1);
        idle(20);
        // R1: downward run through zero (wrap)
        tag = "R1";
        for (int k = 0; k < 12; k++) begin tick(1, 0, 1, 0, 1); tick(0, 0, 1, 0, 1); end
        idle(20);
        // R4: inhibit low, counter keeps running, latch frozen
        tag = "R4";
        tick(0, 1, 0, 0, 1);
        for (int k = 0; k < 6; k++) begin tick(1, 1, 0, 0, 1); idle(4); end
        idle(6);
        // R6: release forces refresh
        tag = "R6";
        tick(0, 1, 1, 0, 1);
        idle(10);
        // R5: inhibit falls mid-pulse
        tag = "R5";
        tick(1, 0, 1, 0, 1);
        tick(0, 0, 0, 0, 1);
        idle(10);
        tick(0, 0, 1, 0, 1);
        idle(8);
        // R5: short inhibit, released before the delay expires
        tick(0, 0, 0, 0, 1);
        tick(0, 0, 0, 0, 1);
        tick(0, 0, 1, 0, 1);
        idle(8);
        // R7 R10: bus controls toggled while stepping
        tag = "R10";
        for (int k = 0; k < 30; k++) tick(k % 3 == 0, 1, 1, k % 2 == 0, k % 5 < 2);
        idle(8);
        // R8: low byte mirrored onto main bus
        tag = "R8";
        for (int k = 0; k < 10; k++) begin tick(1, 1, 1, 0, 0); idle(4); end
        // R10: random mix of all inputs
        tag = "R10";
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom;
            tick(r[0] & r[1], r[2], (r[7:4] != 4'h0), r[8] & r[9], r[10]);
        end
        tick(0, 1, 1, 0, 1);
        idle(12);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: got hang exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule